// File: doc/BRIEF.md
# Request-Acknowledge Timing Monitor

This block is a synthesizable protocol checker for a one-bit request line and a one-bit acknowledge line. A new request is a rising edge of `req`, meaning `req` is high now and was low at the previous clock. Each new request must be answered by an acknowledge between 1 and `WINDOW` clocks later. Once an acknowledge is accepted, the line must drop in the following clock. After that, any acknowledge that does not answer a waiting request is a violation.

Several requests may be outstanding at once. Each one takes the next value of an issue ticket. An acknowledge is credited only to the request whose ticket equals the serve ticket. That request is always the oldest one, so one acknowledge never answers two requests. Every violation produces a one-clock registered pulse on `err_valid`, and `err_cause` gives the reason.

The acknowledge line is tracked by a three-state machine:
- `LINE_OPEN`: no acknowledge has been accepted since reset.
- `LINE_DROP`: the clock after an accepted acknowledge.
- `LINE_QUIET`: the sticky "acknowledge stays low" state.

The transitions are:
- OPEN→DROP and QUIET→DROP when an acknowledge is credited.
- DROP→QUIET on every clock.
- Reset returns the machine to OPEN.

Top module: `reqack_monitor`

## Requirements
- R1: A check starts only when `req` is high and was low at the previous clock. Holding `req` high starts no further checks.
- R2: An acknowledge is credited to the oldest waiting request when it arrives 1 to `WINDOW` (default 10) clocks after that request's edge. An acknowledge in the same clock as the edge does not count for that request.
- R3: If a request receives no acknowledge by its `WINDOW`-th clock, the monitor reports cause 01 (timeout) and drops the request.
- R4: An acknowledge that is high in the clock right after an accepted acknowledge is reported with cause 10. It is not credited.
- R5: An acknowledge with nothing outstanding is reported with cause 10 if an acknowledge has been accepted since reset. Otherwise it is reported with cause 11.
- R6: Up to `SLOTS` (default 4) requests are tracked at once. They are served strictly in arrival order, and both tickets wrap modulo `SLOTS`.
- R7: A single acknowledge, including one held high for several clocks, is credited to at most one request.
- R8: A request edge that arrives while `SLOTS` requests are outstanding is reported with cause 00 and is not tracked, so it can never time out later.
- R9: When several violations fall in the same clock, exactly one is reported. The priority is timeout, then acknowledge-not-low, then spurious, then overflow.
- R10: While `rst_n` is low, `err_valid` and `err_cause` are 0. Reset clears the tickets, the ages and the sticky state, so the first stray acknowledge after reset is reported with cause 11.
- R11: `err_valid` is registered. It pulses for one clock, in the clock after the cycle in which the violation is sampled. `err_cause` is 00 whenever no error is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request line being monitored |
| ack | input | 1 | Acknowledge line being monitored |
| err_valid | output | 1 | One-clock pulse per violation clock |
| err_cause | output | 2 | 00 overflow, 01 timeout, 10 acknowledge not low, 11 spurious acknowledge |

## Verification
Of the checks this block makes, only a timeout of the oldest request and an overflow edge can fire in the same clock:
- A credited acknowledge always comes from a request older than any other waiting request, so a timeout can never land on the clock after a credit.
- A spurious acknowledge needs an empty queue, while a timeout needs a waiting request.

The bench provokes the overlap with four request pulses spaced two clocks apart, then a fifth edge exactly when the first request reaches its tenth clock. It expects cause 01 to win. The behavioural reference model must then show that the untracked fifth request never produces a later timeout.

// File: rtl/reqack_pkg.sv
package reqack_pkg;

    typedef enum logic [1:0] {
        CAUSE_OVERFLOW = 2'b00,
        CAUSE_TIMEOUT  = 2'b01,
        CAUSE_NODROP   = 2'b10,
        CAUSE_SPURIOUS = 2'b11
    } cause_e;

    typedef enum logic [1:0] {
        LINE_OPEN  = 2'b00,
        LINE_DROP  = 2'b01,
        LINE_QUIET = 2'b10
    } line_state_e;

    typedef struct packed {
        logic timeout;
        logic nodrop;
        logic spurious;
        logic overflow;
    } viol_t;

endpackage

// File: rtl/reqack_edge.sv
module reqack_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic rise
);
    logic req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req;
        end
    end

    // New request only on a low-to-high step of the line
    assign rise = req && !req_q;

endmodule

// File: rtl/reqack_ticket_bank.sv
module reqack_ticket_bank #(
    parameter int SLOTS  = 4,
    parameter int AGE_W  = 4,
    parameter int WINDOW = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             retire,
    output logic             head_valid,
    output logic [AGE_W-1:0] head_age,
    output logic             full
);
    localparam int TKT_W = $clog2(SLOTS);
    localparam int CNT_W = TKT_W + 1;
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic [TKT_W-1:0] issue_q;
    logic [TKT_W-1:0] serve_q;
    logic [CNT_W-1:0] count_q;
    logic [SLOTS-1:0] valid_vec;
    logic [AGE_W-1:0] age_arr [SLOTS];
    logic             do_push;

    assign full    = (count_q == CNT_W'(SLOTS));
    assign do_push = push && !full;

    // One slot per ticket value; a slot ages while it waits
    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            logic             v_q;
            logic [AGE_W-1:0] a_q;
            logic             hit_push;
            logic             hit_retire;

            assign hit_push   = do_push && (issue_q == TKT_W'(s));
            assign hit_retire = retire && (serve_q == TKT_W'(s));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q <= 1'b0;
                    a_q <= '0;
                end else if (hit_push) begin
                    v_q <= 1'b1;
                    a_q <= AGE_W'(1);
                end else if (hit_retire) begin
                    v_q <= 1'b0;
                    a_q <= '0;
                end else if (v_q && (a_q != AGE_MAX)) begin
                    a_q <= a_q + AGE_W'(1);
                end
            end

            assign valid_vec[s] = v_q;
            assign age_arr[s]   = a_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issue_q <= '0;
            serve_q <= '0;
            count_q <= '0;
        end else begin
            if (do_push) begin
                issue_q <= issue_q + TKT_W'(1);
            end
            if (retire) begin
                serve_q <= serve_q + TKT_W'(1);
            end
            if (do_push && !retire) begin
                count_q <= count_q + CNT_W'(1);
            end else if (!do_push && retire) begin
                count_q <= count_q - CNT_W'(1);
            end
        end
    end

    assign head_valid = valid_vec[serve_q];
    assign head_age   = age_arr[serve_q];

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(SLOTS)); // R6
    AST_HEAD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid |-> (head_age >= AGE_W'(1) && head_age <= AGE_W'(WINDOW))); // R2
    AST_RETIRE_HAS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> head_valid); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !retire) |=> full); // R8

endmodule

// File: rtl/reqack_line_fsm.sv
module reqack_line_fsm
    import reqack_pkg::*;
#(
    parameter int AGE_W  = 4,
    parameter int WINDOW = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    input  logic             head_valid,
    input  logic [AGE_W-1:0] head_age,
    output logic             credit,
    output logic             timeout,
    output logic             nodrop,
    output logic             spurious
);
    line_state_e state_q;
    line_state_e state_d;
    logic        in_window;

    assign in_window = head_valid && (head_age >= AGE_W'(1))
                       && (head_age <= AGE_W'(WINDOW));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_OPEN:  if (ack && in_window) state_d = LINE_DROP;
            LINE_DROP:  state_d = LINE_QUIET;
            LINE_QUIET: if (ack && in_window) state_d = LINE_DROP;
            default:    state_d = LINE_OPEN;
        endcase
    end

    // Outputs
    always_comb begin
        credit   = 1'b0;
        nodrop   = 1'b0;
        spurious = 1'b0;
        unique case (state_q)
            LINE_OPEN: begin
                credit   = ack && in_window;
                spurious = ack && !in_window;
            end
            LINE_DROP: begin
                nodrop = ack;
            end
            LINE_QUIET: begin
                credit = ack && in_window;
                nodrop = ack && !in_window;
            end
            default: begin
                credit = 1'b0;
            end
        endcase
        timeout = head_valid && (head_age == AGE_W'(WINDOW)) && !credit;
    end

    AST_SINGLE_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        credit |=> !credit); // R7

endmodule

// File: rtl/reqack_err_reg.sv
module reqack_err_reg
    import reqack_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  viol_t       viol,
    output logic        err_valid,
    output logic [1:0]  err_cause
);
    cause_e cause_d;
    logic   any_d;

    assign any_d = viol.timeout || viol.nodrop || viol.spurious || viol.overflow;

    always_comb begin
        if (viol.timeout) begin
            cause_d = CAUSE_TIMEOUT;
        end else if (viol.nodrop) begin
            cause_d = CAUSE_NODROP;
        end else if (viol.spurious) begin
            cause_d = CAUSE_SPURIOUS;
        end else begin
            cause_d = CAUSE_OVERFLOW;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_cause <= 2'b00;
        end else begin
            err_valid <= any_d;
            err_cause <= any_d ? cause_d : 2'b00;
        end
    end

endmodule

// File: rtl/reqack_monitor.sv
module reqack_monitor
    import reqack_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int AGE_W  = 4,
    parameter int WINDOW = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       ack,
    output logic       err_valid,
    output logic [1:0] err_cause
);
    logic             rise;
    logic             head_valid;
    logic [AGE_W-1:0] head_age;
    logic             full;
    logic             credit;
    logic             timeout;
    logic             nodrop;
    logic             spurious;
    logic             retire;
    viol_t            viol;

    reqack_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .rise  (rise)
    );

    reqack_ticket_bank #(
        .SLOTS  (SLOTS),
        .AGE_W  (AGE_W),
        .WINDOW (WINDOW)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (rise),
        .retire     (retire),
        .head_valid (head_valid),
        .head_age   (head_age),
        .full       (full)
    );

    reqack_line_fsm #(
        .AGE_W  (AGE_W),
        .WINDOW (WINDOW)
    ) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack        (ack),
        .head_valid (head_valid),
        .head_age   (head_age),
        .credit     (credit),
        .timeout    (timeout),
        .nodrop     (nodrop),
        .spurious   (spurious)
    );

    assign retire        = credit || timeout;
    assign viol.timeout  = timeout;
    assign viol.nodrop   = nodrop;
    assign viol.spurious = spurious;
    assign viol.overflow = rise && full;

    reqack_err_reg u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .viol      (viol),
        .err_valid (err_valid),
        .err_cause (err_cause)
    );

    AST_HELD_ACK_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(credit) && ack) |=> err_valid); // R4

endmodule

// File: tb/reqack_monitor_tb_top.sv
module reqack_monitor_tb_top;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       req   = 1'b0;
    logic       ack   = 1'b0;
    logic       err_valid;
    logic [1:0] err_cause;

    int n_tests = 0;
    int n_fail  = 0;

    // Behavioural reference state
    int         q[$];
    bit         m_req_prev;
    bit         m_drop;
    bit         m_sticky;
    bit         exp_v;
    logic [1:0] exp_c;

    reqack_monitor dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .ack       (ack),
        .err_valid (err_valid),
        .err_cause (err_cause)
    );

    always #4 clk = ~clk;

    task automatic model(bit r, bit a);
        bit rise, cred, tmo, nd, sp, ov;
        if (!rst_n) begin
            q.delete();
            m_req_prev = 1'b0;
            m_drop     = 1'b0;
            m_sticky   = 1'b0;
            exp_v      = 1'b0;
            exp_c      = 2'b00;
            return;
        end
        rise = r && !m_req_prev;
        ov   = rise && (q.size() == 4);
        cred = a && (q.size() > 0) && !m_drop;
        nd   = a && (m_drop || (q.size() == 0 && m_sticky));
        sp   = a && !m_drop && (q.size() == 0) && !m_sticky;
        tmo  = (q.size() > 0) && (q[0] == 10) && !cred;
        if (cred || tmo) void'(q.pop_front());
        foreach (q[i]) q[i]++;
        if (rise && !ov) q.push_back(1);
        m_drop     = cred;
        m_sticky   = m_sticky | cred;
        m_req_prev = r;
        exp_v      = tmo | nd | sp | ov;
        exp_c      = tmo ? 2'b01 : nd ? 2'b10 : sp ? 2'b11 : 2'b00;
    endtask

    task automatic step(bit r, bit a, string tag);
        req = r;
        ack = a;
        model(r, a);
        @(posedge clk);
        @(negedge clk);
        n_tests++;
        if (err_valid !== exp_v || err_cause !== exp_c) begin
            n_fail++;
            $display("FAIL %s: actual valid=%0b cause=%b, expected valid=%0b cause=%b",
                     tag, err_valid, err_cause, exp_v, exp_c);
        end
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R10 outputs low in reset");
        rst_n = 1'b1;

        // Stray ack before anything was accepted
        step(1'b0, 1'b1, "R5 spurious ack gives 11");
        step(1'b0, 1'b0, "R11 pulse lasts one clock");

        // Ack in edge clock, then in the next clock
        step(1'b1, 1'b1, "R2 ack in edge clock not credited");
        step(1'b1, 1'b1, "R2 ack one clock after edge credited");
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0, "R1 held req starts no check");
        step(1'b0, 1'b0, "R1 req release");
        step(1'b0, 1'b1, "R5 stray ack after accept gives 10");
        idle(2, "R5 quiet");

        // Timeout
        step(1'b1, 1'b0, "R3 edge");
        idle(9, "R3 waiting inside window");
        step(1'b0, 1'b0, "R3 timeout at tenth clock");
        idle(2, "R11 no repeat after timeout");

        // Ack at the window limit
        step(1'b1, 1'b0, "R2 edge");
        idle(9, "R2 waiting");
        step(1'b0, 1'b1, "R2 ack at tenth clock credited");
        idle(2, "R2 after limit ack");

        // Ack not dropping
        step(1'b1, 1'b0, "R4 edge");
        step(1'b0, 1'b0, "R4 wait");
        step(1'b0, 1'b1, "R4 ack credited");
        step(1'b0, 1'b1, "R4 ack held gives 10");
        idle(2, "R4 settle");

        // Four outstanding, fifth overflows, in-order service
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b0, "R6 queued edge");
            step(1'b0, 1'b0, "R6 gap");
        end
        step(1'b1, 1'b0, "R8 fifth edge overflows");
        step(1'b0, 1'b1, "R6 oldest served");
        step(1'b0, 1'b0, "R6 drop");
        step(1'b0, 1'b1, "R6 second served");
        step(1'b0, 1'b0, "R6 drop");
        step(1'b0, 1'b1, "R6 third served");
        idle(3, "R6 fourth waits");
        idle(10, "R8 untracked request never times out");

        // Timeout and overflow in the same clock
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b0, "R9 queued edge");
            step(1'b0, 1'b0, "R9 gap");
        end
        idle(2, "R9 aging");
        step(1'b1, 1'b0, "R9 timeout beats overflow");
        idle(12, "R3 queued timeouts");

        // Held ack credits only one request
        step(1'b1, 1'b0, "R7 first edge");
        step(1'b0, 1'b0, "R7 gap");
        step(1'b1, 1'b0, "R7 second edge");
        step(1'b0, 1'b1, "R7 first credited");
        step(1'b0, 1'b1, "R7 held ack not credited to second");
        idle(10, "R7 second still times out");

        // Reset in the middle of activity
        step(1'b1, 1'b0, "R10 edge before reset");
        rst_n = 1'b0;
        step(1'b0, 1'b0, "R10 reset clears");
        rst_n = 1'b1;
        step(1'b0, 1'b1, "R10 sticky cleared gives 11");
        idle(12, "R10 dropped request silent");

        // Random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) == 0, ($urandom % 8) == 0, "R11 random traffic");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule